// File: doc/BRIEF.md
# Reference Impairment Monitor with Holdover

This block supervises an incoming reference clock by sampling it with a fast local clock. On every rising reference edge it counts the sampling cycles since the previous edge and compares the count with a programmable window. A period that is too short, a period that is too long, or a reference that goes silent is an impairment. The block then moves its mode output to holdover. Recovery needs a run of consecutive good periods.

Alongside the monitor, the block keeps a circular history of the frequency word supplied by the external loop, one sample per history tick. While in normal mode, entering holdover freezes an output word. That word is the mean of samples that are well in the past, so the samples taken while the reference was already failing do not affect it. The loop filter, the oscillator and any phase correction sit outside this block. They read the mode output and the frozen word.

Top module: `ref_mon`

## Requirements
- R1: A synchronous reset clears the frequency history to zero, sets the mode to normal (holdover = 0) and sets hold_word to 0. If the reference is lost right after reset, before any history tick, the frozen word is therefore 0.
- R2: In normal mode, rising edges whose measured period P (sampling cycles between successive rising edges) satisfies lim_lo <= P <= lim_hi keep the mode at normal.
- R3: In normal mode, a measured period below lim_lo sets holdover = 1 on the cycle after that edge is detected.
- R4: In normal mode, a measured period above lim_hi sets holdover = 1 on the cycle after that edge is detected.
- R5: If no rising edge is seen for LOS_CYC = 4 * NOM_PERIOD sampling cycles, the reference is declared lost and holdover goes to 1. This does not happen earlier.
- R6: Every TICK_CYCLES sampling cycles in normal mode, freq_in is written into a DEPTH-entry circular history. On entry to holdover, hold_word becomes the mean of the 2^AVG_LOG2 samples whose ages are AGE_MIN, AGE_MIN+AGE_STEP, and so on (by default ages 30, 32, ..., 60 ticks, where age 0 is the newest). The mean is the sum shifted right by AVG_LOG2.
- R7: While in holdover, hold_word stays constant whatever freq_in does, and the history records nothing.
- R8: The mode returns to normal once RUN_LEN (16) consecutive in-range periods have been measured while in holdover. Any out-of-range period or loss condition restarts that run. hold_word keeps its frozen value after the return to normal.
- R9: The first rising edge after reset only starts the period count and is not judged against the window.
- R10: holdover and hold_word change only on sampling-clock edges, and hold_word changes only on a cycle where holdover rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference clock under supervision (asynchronous) |
| freq_in | input | FREQ_W | Current frequency word from the loop |
| lim_lo | input | PER_W | Shortest accepted period, in sampling cycles |
| lim_hi | input | PER_W | Longest accepted period, in sampling cycles |
| holdover | output | 1 | 1 = holdover mode, 0 = normal mode |
| hold_word | output | FREQ_W | Frozen frequency word for holdover |

## Verification
On every cycle, the assertions check the following. A bad edge or a loss seen in normal mode forces holdover on the next cycle. The frozen word never moves during holdover and changes only when holdover rises. Holdover is left only after a full run of good periods, and the outputs are clean after reset. The bench scenarios are needed for everything that depends on history and exact counts. Those are the averaged value taken from old samples across a step in freq_in, the boundary between 15 and 16 good periods, the restart of the run after one bad period, the loss threshold measured from the last edge, and the zeroed history after a second reset.

// File: rtl/ref_mon_pkg.sv
package ref_mon_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_HOLD   = 1'b1
    } mon_mode_e;

endpackage

// File: rtl/ref_period_meter.sv
module ref_period_meter #(
    parameter int NOM_PERIOD = 125,
    parameter int PER_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_in,
    input  logic [PER_W-1:0] lim_lo,
    input  logic [PER_W-1:0] lim_hi,
    output logic             edge_ok,
    output logic             edge_bad,
    output logic             los
);
    localparam int LOS_CYC = 4 * NOM_PERIOD;
    localparam int CNT_W   = $clog2(LOS_CYC + 1);

    typedef struct packed {
        logic [2:0]       sync;
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } meter_t;

    meter_t st_d, st_q;
    logic   rise;
    logic   in_win;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[1:0], ref_in};
        rise      = st_q.sync[1] & ~st_q.sync[2];
        in_win    = (int'(st_q.cnt) >= int'(lim_lo)) && (int'(st_q.cnt) <= int'(lim_hi));
        edge_ok   = rise && st_q.armed && in_win;
        edge_bad  = rise && st_q.armed && !in_win;
        los       = !rise && (st_q.cnt == CNT_W'(LOS_CYC));
        if (rise) begin
            st_d.cnt   = CNT_W'(1);
            st_d.armed = 1'b1;
        end else if (st_q.cnt != CNT_W'(LOS_CYC)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/freq_history.sv
module freq_history #(
    parameter int FREQ_W      = 24,
    parameter int DEPTH       = 64,
    parameter int TICK_CYCLES = 125000,
    parameter int AGE_MIN     = 30,
    parameter int AGE_STEP    = 2,
    parameter int AVG_LOG2    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rec_en,
    input  logic [FREQ_W-1:0] freq_in,
    output logic [FREQ_W-1:0] avg_word
);
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int TICK_W = $clog2(TICK_CYCLES);
    localparam int AVG_N  = 1 << AVG_LOG2;
    localparam int SUM_W  = FREQ_W + AVG_LOG2;

    typedef struct packed {
        logic [DEPTH-1:0][FREQ_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [TICK_W-1:0]            tick;
    } hist_t;

    hist_t             st_d, st_q;
    logic [FREQ_W-1:0] tap [AVG_N];
    logic [SUM_W-1:0]  sum;

    for (genvar k = 0; k < AVG_N; k++) begin : g_tap
        localparam int AGE_K = AGE_MIN + k * AGE_STEP;
        assign tap[k] = st_q.mem[st_q.wr_ptr - PTR_W'(AGE_K + 1)];
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < AVG_N; k++) begin
            sum = sum + SUM_W'(tap[k]);
        end
        avg_word = sum[SUM_W-1:AVG_LOG2];
    end

    always_comb begin
        st_d = st_q;
        if (st_q.tick == TICK_W'(TICK_CYCLES - 1)) begin
            st_d.tick = '0;
            if (rec_en) begin
                st_d.mem[st_q.wr_ptr] = freq_in;
                st_d.wr_ptr           = st_q.wr_ptr + PTR_W'(1);
            end
        end else begin
            st_d.tick = st_q.tick + TICK_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ref_mon.sv
module ref_mon
    import ref_mon_pkg::*;
#(
    parameter int NOM_PERIOD  = 125,
    parameter int PER_W       = 16,
    parameter int FREQ_W      = 24,
    parameter int DEPTH       = 64,
    parameter int TICK_CYCLES = 125000,
    parameter int AGE_MIN     = 30,
    parameter int AGE_STEP    = 2,
    parameter int AVG_LOG2    = 4,
    parameter int RUN_LEN     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic [FREQ_W-1:0] freq_in,
    input  logic [PER_W-1:0]  lim_lo,
    input  logic [PER_W-1:0]  lim_hi,
    output logic              holdover,
    output logic [FREQ_W-1:0] hold_word
);
    localparam int RUN_W = $clog2(RUN_LEN);

    typedef struct packed {
        mon_mode_e         mode;
        logic [RUN_W-1:0]  good;
        logic [FREQ_W-1:0] word;
    } ctl_t;

    ctl_t              st_d, st_q;
    logic              edge_ok, edge_bad, los;
    logic [FREQ_W-1:0] avg_word;
    logic [RUN_W-1:0]  good_run;

    ref_period_meter #(
        .NOM_PERIOD(NOM_PERIOD),
        .PER_W     (PER_W)
    ) u_meter (
        .clk     (clk),
        .rst     (rst),
        .ref_in  (ref_in),
        .lim_lo  (lim_lo),
        .lim_hi  (lim_hi),
        .edge_ok (edge_ok),
        .edge_bad(edge_bad),
        .los     (los)
    );

    freq_history #(
        .FREQ_W     (FREQ_W),
        .DEPTH      (DEPTH),
        .TICK_CYCLES(TICK_CYCLES),
        .AGE_MIN    (AGE_MIN),
        .AGE_STEP   (AGE_STEP),
        .AVG_LOG2   (AVG_LOG2)
    ) u_hist (
        .clk     (clk),
        .rst     (rst),
        .rec_en  (st_q.mode == MODE_NORMAL),
        .freq_in (freq_in),
        .avg_word(avg_word)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_NORMAL: begin
                if (edge_bad || los) begin
                    st_d.mode = MODE_HOLD;
                    st_d.word = avg_word;
                    st_d.good = '0;
                end
            end
            MODE_HOLD: begin
                if (edge_bad || los) begin
                    st_d.good = '0;
                end else if (edge_ok) begin
                    if (st_q.good == RUN_W'(RUN_LEN - 1)) begin
                        st_d.mode = MODE_NORMAL;
                        st_d.good = '0;
                    end else begin
                        st_d.good = st_q.good + RUN_W'(1);
                    end
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{mode: MODE_NORMAL, good: '0, word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign holdover  = (st_q.mode == MODE_HOLD);
    assign hold_word = st_q.word;
    assign good_run  = st_q.good;
endmodule

// File: rtl/ref_mon_chk.sv
module ref_mon_chk #(
    parameter int FREQ_W  = 24,
    parameter int RUN_LEN = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       holdover,
    input logic [FREQ_W-1:0]          hold_word,
    input logic                       edge_ok,
    input logic                       edge_bad,
    input logic                       los,
    input logic [$clog2(RUN_LEN)-1:0] good_run
);
    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!holdover && hold_word == '0));

    a_r2_stays_normal: assert property (@(posedge clk) disable iff (rst)
        (!holdover && !edge_bad && !los) |=> !holdover);

    a_r3_r4_bad_edge_enters: assert property (@(posedge clk) disable iff (rst)
        (!holdover && edge_bad) |=> holdover);

    a_r5_loss_enters: assert property (@(posedge clk) disable iff (rst)
        (!holdover && los) |=> holdover);

    a_r7_word_frozen: assert property (@(posedge clk) disable iff (rst)
        (holdover && $past(holdover)) |-> $stable(hold_word));

    a_r10_word_moves_on_entry: assert property (@(posedge clk) disable iff (rst)
        !$stable(hold_word) |-> $rose(holdover));

    a_r8_exit_after_run: assert property (@(posedge clk) disable iff (rst)
        $fell(holdover) |-> ($past(edge_ok) && $past(good_run) == ($clog2(RUN_LEN))'(RUN_LEN - 1)));
endmodule

bind ref_mon ref_mon_chk #(
    .FREQ_W (FREQ_W),
    .RUN_LEN(RUN_LEN)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .holdover (holdover),
    .hold_word(hold_word),
    .edge_ok  (edge_ok),
    .edge_bad (edge_bad),
    .los      (los),
    .good_run (good_run)
);

// File: tb/ref_mon_test.sv
module ref_mon_test;
    localparam int FW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ref_in = 1'b0;
    logic [FW-1:0] freq_in = '0;
    logic [7:0]    lim_lo = 8'd8;
    logic [7:0]    lim_hi = 8'd12;
    logic          holdover;
    logic [FW-1:0] hold_word;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        string   tag;
        bit      hold;
        bit      chk_word;
        int      word;
    } exp_t;

    exp_t sb_q[$];
    event sample_ev;

    ref_mon #(
        .NOM_PERIOD (10),
        .PER_W      (8),
        .FREQ_W     (FW),
        .DEPTH      (64),
        .TICK_CYCLES(64),
        .AGE_MIN    (30),
        .AGE_STEP   (2),
        .AVG_LOG2   (4),
        .RUN_LEN    (16)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .ref_in   (ref_in),
        .freq_in  (freq_in),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi),
        .holdover (holdover),
        .hold_word(hold_word)
    );

    always #4 clk = ~clk;

    task automatic expect_state(string tag, bit h, bit cw, int w);
        exp_t e;
        e.tag = tag; e.hold = h; e.chk_word = cw; e.word = w;
        sb_q.push_back(e);
        -> sample_ev;
    endtask

    task automatic drain();
        exp_t e;
        while (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_run++;
            if (holdover !== e.hold) begin
                n_fail++;
                $display("FAIL %s: holdover=%0b expected %0b", e.tag, holdover, e.hold);
            end else if (e.chk_word && hold_word !== FW'(e.word)) begin
                n_fail++;
                $display("FAIL %s: hold_word=%0d expected %0d", e.tag, hold_word, e.word);
            end
        end
    endtask

    initial begin : monitor
        forever begin
            @(sample_ev);
            drain();
        end
    end

    task automatic pulse(int p);
        ref_in = 1'b1;
        repeat (p / 2) @(negedge clk);
        ref_in = 1'b0;
        repeat (p - p / 2) @(negedge clk);
    endtask

    task automatic pulses(int n, int p);
        for (int i = 0; i < n; i++) pulse(p);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        expect_state("R1 reset state", 1'b0, 1'b1, 0);

        // R2 R9: steady in-range reference from right after reset
        freq_in = 16'd1000;
        pulses(448, 10);
        expect_state("R2 R9 in-range stays normal", 1'b0, 1'b1, 0);

        // R6: step in freq_in, then loss of reference
        freq_in = 16'd2000;
        pulses(288, 10);
        repeat (25) @(negedge clk);
        expect_state("R5 no loss before threshold", 1'b0, 1'b0, 0);
        repeat (20) @(negedge clk);
        expect_state("R5 R6 loss enters holdover with old average", 1'b1, 1'b1, 1500);

        // R7 R8: frozen word, run of 16 good periods
        freq_in = 16'd7777;
        pulses(16, 10);
        expect_state("R7 R8 still holdover after 15 good", 1'b1, 1'b1, 1500);
        pulse(10);
        expect_state("R8 normal after 16 good, word kept", 1'b0, 1'b1, 1500);

        // R4: too-slow period
        pulse(14);
        pulse(10);
        expect_state("R4 long period enters holdover", 1'b1, 1'b0, 0);

        // R8: a bad period restarts the run
        pulses(10, 10);
        pulse(13);
        pulses(16, 10);
        expect_state("R8 run restarted by bad period", 1'b1, 1'b0, 0);
        pulse(10);
        expect_state("R8 normal after restarted run", 1'b0, 1'b0, 0);

        // R3: too-fast period
        pulse(6);
        pulse(10);
        expect_state("R3 short period enters holdover", 1'b1, 1'b0, 0);
        pulses(16, 10);
        expect_state("R8 recover after short period", 1'b0, 1'b0, 0);

        // R1 R5: second reset clears history, loss before first tick
        ref_in  = 1'b0;
        freq_in = 16'd5555;
        rst     = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        expect_state("R1 second reset state", 1'b0, 1'b1, 0);
        repeat (30) @(negedge clk);
        expect_state("R5 silent but below threshold", 1'b0, 1'b1, 0);
        repeat (20) @(negedge clk);
        expect_state("R1 R5 cleared history gives zero word", 1'b1, 1'b1, 0);

        #1;
        drain();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule